// File: doc/BRIEF.md
# Double-Buffered Serial Port with Interrupt Flags

This block is an asynchronous serial transmitter and receiver using 8N1 framing (one start bit, eight data bits sent least significant bit first, one stop bit). Each direction has a single holding buffer in front of a shift register. Software reaches the buffers, the status flags and the interrupt enables through a small register bus. An external per-bit baud tick paces both shifters.

Three interrupt request lines come out of the block. The receive request is active while a received character waits in the receive buffer. The transmit request is active while the transmit buffer may take a new character. The end request is active once the line has gone quiet with nothing queued behind the last character. A driver keeps a continuous stream going by refilling the transmit buffer and draining the receive buffer before each shifter finishes its current character.

Top module: `sio_dbuf_irq`

## Requirements
- R1: After reset the status register reads 0x03: empty flag (bit 0) = 1, end flag (bit 1) = 1, full flag (bit 2) = 0 and overrun flag (bit 3) = 0. The control register reads 0, `tx_o` is 1 and all three interrupt outputs are 0.
- R2: Bus map, selected by `bus_addr`:
  - 0: writes the transmit buffer and reads as 0.
  - 1: reads the receive buffer.
  - 2: reads the status register with the flags in bits 3..0. A write that holds 0 in bit 0, 2 or 3 clears the empty, full or overrun flag.
  - 3: the control register. Bit 0 enables the receive request, bit 1 the transmit request and bit 2 the end request.
  - `bus_rdata` follows `bus_addr` combinationally.
- R3: When the transmit shifter is idle and the empty flag is 0, the transmit buffer moves into the shifter on the next clock edge, and that same edge sets the empty flag to 1.
- R4: Once loaded, the shifter puts out the start bit (0) on the next baud tick. It then puts out the eight data bits, least significant first, and the stop bit (1), one on each following tick. `tx_o` is 1 whenever no frame is in progress.
- R5: The tick after the stop bit ends the frame. If the empty flag is 1 at that point, the end flag is set. If it is 0, the end flag stays 0 and the buffered character is loaded on the next edge, giving back-to-back frames.
- R6: A write that clears the empty flag also clears the end flag.
- R7: The receiver samples `rx_i` through a two-stage synchronizer on each tick. A low sample starts a frame. On the tick that samples a high stop bit, with the full and overrun flags both 0, the character goes into the receive buffer and the full flag is set. A frame with a low stop bit is discarded.
- R8: A frame that completes while the full flag or the overrun flag is 1 leaves the receive buffer unchanged and sets the overrun flag. The full flag is not set while the overrun flag is 1.
- R9: `irq_rx` equals the full flag ANDed with control bit 0.
- R10: `irq_tx` equals the empty flag ANDed with control bit 1.
- R11: `irq_te` equals the end flag ANDed with control bit 2.
- R12: Writing 1 to any status bit has no effect. Software cannot set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle baud pulse, one per bit period |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_te | output | 1 | Transmit-end interrupt request |

## Verification
- A status clear takes effect at the first edge after the write. On an idle transmitter the empty flag therefore reads 0 for exactly one cycle before the load edge sets it again, and the bench checks the status on both of those cycles.
- Line bits change one edge after each tick, and the end flag is set one edge after the eleventh tick of a frame.
- The full flag is set on the edge of the tick that samples the stop bit, two synchronizer cycles after the line changes.
- A cycle-level reference model in the bench is advanced on each rising edge from the same inputs. The line, the interrupts and the read data are compared two nanoseconds after that edge, so every result is sampled in the cycle it is due. Directed status checks wait well beyond the frame lengths before they read.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

    typedef enum logic [1:0] {
        REG_TXBUF = 2'd0,
        REG_RXBUF = 2'd1,
        REG_STAT  = 2'd2,
        REG_CTRL  = 2'd3
    } sio_reg_e;

    // status bit order: bit0 empty, bit1 end, bit2 full, bit3 overrun
    typedef struct packed {
        logic ovr;
        logic full;
        logic tend;
        logic empty;
    } sio_stat_t;

    typedef struct packed {
        logic te_en;
        logic tx_en;
        logic rx_en;
    } sio_ctrl_t;

    localparam int unsigned STAT_W = $bits(sio_stat_t);
    localparam int unsigned CTRL_W = $bits(sio_ctrl_t);

    function automatic int unsigned frame_bits(int unsigned data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              done,
    output logic              tx
);
    import sio_pkg::*;

    localparam int unsigned FRAME = frame_bits(DATA_W);
    localparam int unsigned CW    = $clog2(FRAME + 1);

    logic [FRAME-1:0] frame_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             tx_q;

    assign busy = busy_q;
    assign tx   = tx_q;
    assign done = busy_q && tick && (cnt_q == CW'(FRAME));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            tx_q    <= 1'b1;
        end else if (load) begin
            frame_q <= {1'b1, load_data, 1'b0};
            cnt_q   <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q && tick) begin
            if (cnt_q == CW'(FRAME)) begin
                busy_q <= 1'b0;
            end else begin
                tx_q    <= frame_q[0];
                frame_q <= {1'b1, frame_q[FRAME-1:1]};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // R3: a load is only accepted by an idle shifter
    p_load_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q) else $error("load while busy");

    // R4: line rests high between frames
    p_line_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> tx_q) else $error("idle line not high");

endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned CW = $clog2(DATA_W + 1);

    logic              rx_s;
    logic              active_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] shift_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign rx_s = rx;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], rx} >> 0;
            end
            assign rx_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    assign done = tick && active_q && (cnt_q == CW'(DATA_W)) && rx_s;
    assign data = shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
        end else if (tick) begin
            if (!active_q) begin
                if (!rx_s) begin
                    active_q <= 1'b1;
                    cnt_q    <= '0;
                end
            end else if (cnt_q != CW'(DATA_W)) begin
                shift_q <= {rx_s, shift_q[DATA_W-1:1]};
                cnt_q   <= cnt_q + 1'b1;
            end else begin
                active_q <= 1'b0;
            end
        end
    end

    // R7: a completed frame is reported in a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("repeated rx done");

endmodule

// File: rtl/sio_dbuf_irq.sv
`timescale 1ns/1ps
module sio_dbuf_irq #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_i,
    output logic              tx_o,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_te
);
    import sio_pkg::*;

    sio_stat_t         stat_q;
    sio_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] tdr_q;
    logic [DATA_W-1:0] rdr_q;

    logic tx_busy, tx_done, rx_done;
    logic [DATA_W-1:0] rx_data;

    logic wr_buf, wr_stat, wr_ctrl, clr_empty, load;

    assign wr_buf    = bus_we && (bus_addr == REG_TXBUF);
    assign wr_stat   = bus_we && (bus_addr == REG_STAT);
    assign wr_ctrl   = bus_we && (bus_addr == REG_CTRL);
    assign clr_empty = wr_stat && !bus_wdata[0];
    assign load      = !tx_busy && !stat_q.empty;

    sio_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .load(load), .load_data(tdr_q),
        .busy(tx_busy), .done(tx_done), .tx(tx_o)
    );

    sio_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rx(rx_i),
        .done(rx_done), .data(rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{ovr: 1'b0, full: 1'b0, tend: 1'b1, empty: 1'b1};
            ctrl_q <= '0;
            tdr_q  <= '0;
            rdr_q  <= '0;
        end else begin
            if (wr_buf)  tdr_q  <= bus_wdata;
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];

            if (load)           stat_q.empty <= 1'b1;
            else if (clr_empty) stat_q.empty <= 1'b0;

            if (clr_empty)                    stat_q.tend <= 1'b0;
            else if (tx_done && stat_q.empty) stat_q.tend <= 1'b1;

            if (rx_done && !stat_q.full && !stat_q.ovr) begin
                stat_q.full <= 1'b1;
                rdr_q       <= rx_data;
            end else if (wr_stat && !bus_wdata[2]) begin
                stat_q.full <= 1'b0;
            end

            if (rx_done && (stat_q.full || stat_q.ovr)) stat_q.ovr <= 1'b1;
            else if (wr_stat && !bus_wdata[3])          stat_q.ovr <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            REG_RXBUF: bus_rdata = rdr_q;
            REG_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
            REG_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_rx = stat_q.full  && ctrl_q.rx_en;
    assign irq_tx = stat_q.empty && ctrl_q.tx_en;
    assign irq_te = stat_q.tend  && ctrl_q.te_en;

    // R3: moving the buffer into the shifter sets the empty flag
    p_load_sets_empty_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> stat_q.empty) else $error("empty not set on load");

    // R5: end flag only rises at frame end with the empty flag already set
    p_end_needs_empty_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.tend) |-> ($past(stat_q.empty) && $past(tx_done)))
        else $error("end flag rose without empty");

    // R6: clearing the empty flag drops the end flag
    p_clear_drops_end_r6: assert property (@(posedge clk) disable iff (rst)
        clr_empty |=> !stat_q.tend) else $error("end flag survived clear");

    // R8: overrun keeps the receive buffer and raises the overrun flag
    p_overrun_keeps_buf_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && (stat_q.full || stat_q.ovr)) |=> (stat_q.ovr && $stable(rdr_q)))
        else $error("buffer changed on overrun");

endmodule

// File: tb/sio_dbuf_irq_bench.sv
`timescale 1ns/1ps
module sio_dbuf_irq_bench;

    localparam int TICK_DIV = 8;
    localparam int MAX_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx_i = 1'b1;
    logic       tx_o;
    logic [1:0] bus_addr = 2'd2;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_rx, irq_tx, irq_te;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tcnt = 0;
    bit rx_q[$];

    always #4 clk = ~clk;

    sio_dbuf_irq u_sio_dbuf_irq (
        .clk(clk), .rst(rst), .tick(tick), .rx_i(rx_i), .tx_o(tx_o),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_te(irq_te)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // stimulus driver for baud tick and serial receive line
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            tcnt = 0; tick = 1'b0; rx_i = 1'b1;
        end else begin
            tcnt = (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
            tick = (tcnt == 0);
            if (tcnt == TICK_DIV/2) rx_i = (rx_q.size() > 0) ? rx_q.pop_front() : 1'b1;
        end
        if (cyc > MAX_CYC) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, MAX_CYC);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // behavioural reference model
    bit m_empty, m_end, m_full, m_ovr, m_tx, m_busy;
    bit [2:0] m_ctrl;
    bit [7:0] m_tdr, m_rdr;
    bit m_s1, m_s2;
    int m_rxph;
    bit [7:0] m_rxd;
    bit m_tq[$];

    always @(posedge clk) begin
        bit done_t, done_r, clr, ld, rs;
        if (rst) begin
            m_empty = 1; m_end = 1; m_full = 0; m_ovr = 0; m_tx = 1; m_busy = 0;
            m_ctrl = 0; m_tdr = 0; m_rdr = 0; m_s1 = 1; m_s2 = 1; m_rxph = -1;
            m_rxd = 0; m_tq.delete();
        end else begin
            rs = m_s2; m_s2 = m_s1; m_s1 = rx_i;
            done_t = m_busy && tick && (m_tq.size() == 0);
            ld = !m_busy && !m_empty;
            clr = bus_we && bus_addr == 2'd2 && !bus_wdata[0];
            done_r = 0;
            if (tick) begin
                if (m_rxph < 0) begin
                    if (!rs) begin m_rxph = 0; m_rxd = 0; end
                end else if (m_rxph < 8) begin
                    m_rxd[m_rxph] = rs; m_rxph++;
                end else begin
                    m_rxph = -1; done_r = rs;
                end
            end
            if (ld) begin
                m_tq.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_tq.push_back(m_tdr[i]);
                m_tq.push_back(1'b1);
                m_busy = 1;
            end else if (m_busy && tick) begin
                if (m_tq.size() > 0) m_tx = m_tq.pop_front();
                else m_busy = 0;
            end
            if (clr) m_end = 0;
            else if (done_t && m_empty) m_end = 1;
            if (ld) m_empty = 1;
            else if (clr) m_empty = 0;
            if (done_r && (m_full || m_ovr)) m_ovr = 1;
            else if (bus_we && bus_addr == 2'd2 && !bus_wdata[3]) m_ovr = 0;
            if (done_r && !m_full && (m_ovr == 0 || !(done_r && m_ovr))) begin
                if (!m_full) begin m_full = 1; m_rdr = m_rxd; end
            end else if (bus_we && bus_addr == 2'd2 && !bus_wdata[2]) m_full = 0;
            if (bus_we && bus_addr == 2'd0) m_tdr = bus_wdata;
            if (bus_we && bus_addr == 2'd3) m_ctrl = bus_wdata[2:0];
        end
        #2;
        if (!rst) begin
            check("R4 tx line", tx_o, m_tx);
            check("R9 irq_rx", irq_rx, m_full && m_ctrl[0]);
            check("R10 irq_tx", irq_tx, m_empty && m_ctrl[1]);
            check("R11 irq_te", irq_te, m_end && m_ctrl[2]);
            case (bus_addr)
                2'd0: check("R2 rdata txbuf", bus_rdata, 0);
                2'd1: check("R2 rdata rxbuf", bus_rdata, m_rdr);
                2'd2: check("R2 rdata status", bus_rdata, {m_ovr, m_full, m_end, m_empty});
                default: check("R2 rdata ctrl", bus_rdata, m_ctrl);
            endcase
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd2;
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input int exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 2'd2;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit good_stop);
        rx_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) rx_q.push_back(d[i]);
        rx_q.push_back(good_stop);
        wait (rx_q.size() == 0);
        repeat (3*TICK_DIV) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_chk("R1 status after reset", 2'd2, 8'h03);
        read_chk("R1 ctrl after reset", 2'd3, 8'h00);
        check("R1 tx idle high", tx_o, 1);
        check("R1 irqs low", {irq_rx, irq_tx, irq_te}, 0);

        bus_write(2'd3, 8'h07);
        check("R10 irq_tx enabled", irq_tx, 1);
        check("R11 irq_te enabled", irq_te, 1);

        // R3 / R6 single character
        bus_write(2'd0, 8'hA5);
        bus_write(2'd2, 8'hFE);
        read_chk("R6 clear empty drops end", 2'd2, 8'h00);
        @(negedge clk);
        read_chk("R3 load sets empty", 2'd2, 8'h01);

        // R5 continuous transmission
        bus_write(2'd0, 8'h3C);
        bus_write(2'd2, 8'hFE);
        repeat (60) @(negedge clk);
        read_chk("R5 second char waiting", 2'd2, 8'h00);
        repeat (40) @(negedge clk);
        read_chk("R5 no end between frames", 2'd2, 8'h01);
        repeat (120) @(negedge clk);
        read_chk("R5 end after last frame", 2'd2, 8'h03);

        // R12 writing ones changes nothing
        bus_write(2'd2, 8'hFF);
        read_chk("R12 ones ignored", 2'd2, 8'h03);

        // R7 reception
        send_rx(8'h5A, 1'b1);
        read_chk("R7 full set", 2'd2, 8'h07);
        read_chk("R7 rx data", 2'd1, 8'h5A);
        check("R9 irq_rx on full", irq_rx, 1);
        bus_write(2'd2, 8'hFB);
        read_chk("R7 full cleared", 2'd2, 8'h03);
        send_rx(8'h77, 1'b0);
        read_chk("R7 bad stop discarded", 2'd2, 8'h03);
        read_chk("R7 buffer kept on bad stop", 2'd1, 8'h5A);

        // R8 overrun
        send_rx(8'h11, 1'b1);
        read_chk("R8 first char", 2'd1, 8'h11);
        send_rx(8'h22, 1'b1);
        read_chk("R8 overrun flag", 2'd2, 8'h0F);
        read_chk("R8 buffer kept", 2'd1, 8'h11);
        bus_write(2'd2, 8'hFB);
        send_rx(8'h33, 1'b1);
        read_chk("R8 full blocked by overrun", 2'd2, 8'h0B);
        read_chk("R8 buffer still kept", 2'd1, 8'h11);
        bus_write(2'd2, 8'hF7);
        send_rx(8'h44, 1'b1);
        read_chk("R8 resumes after clear", 2'd2, 8'h07);
        read_chk("R8 new data", 2'd1, 8'h44);

        // R9-R11 masking
        bus_write(2'd3, 8'h00);
        check("R9 irq_rx masked", irq_rx, 0);
        check("R10 irq_tx masked", irq_tx, 0);
        check("R11 irq_te masked", irq_te, 0);
        bus_write(2'd3, 8'h01);
        check("R9 irq_rx only", {irq_rx, irq_tx, irq_te}, 3'b100);

        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule